// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit general registers of a small 32-bit core, together with the shadow copies that each processor mode owns. The pipeline reads two registers and writes one register every cycle. When the core changes mode, it raises a one-cycle request that carries the target mode. In that cycle the block exchanges the live banked registers with the bank of the new mode. Registers r13 and r14 are banked in every exception mode. In fast-interrupt mode, r8 through r12 are banked as well.

The block keeps a current status word, with the mode in bits [4:0] and the interrupt masks in bits 7 and 6. It also keeps a live saved-status copy, which a separate write port can update. On a switch, that copy is stored into the outgoing mode's slot, and the incoming mode's slot is loaded in its place.

All accesses complete in one cycle. No port has a handshake or back-pressure: reads are combinational from the live registers, and writes land at the next clock edge. Mode encodings are user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F.

Top module: `banked_regfile`

## Requirements
- R1: After reset, r13 reads 0x10000000 and every other register, r15 included, reads 0. The status word is 0x000000D3, which is supervisor mode with both interrupt masks set, and the saved-status output is 0.
- R2: The read data of both ports shows the addressed live register combinationally. A write with wr_en high updates the addressed register at the next rising edge.
- R3: User (0x10) and system (0x1F) share one r13/r14 pair. In these two modes the saved-status output reads 0 and saved-status writes are ignored.
- R4: The interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes each keep a private r13, r14 and saved status, and these are restored unchanged when the mode is re-entered.
- R5: Fast-interrupt mode (0x11) keeps private copies of r8 to r14 and of the saved status. After leaving it, r8 to r12 again show the values they held before fast-interrupt mode was entered.
- R6: A mode request whose target equals the current mode changes no banked state and no status.
- R7: A mode request whose target is not one of the seven listed encodings is rejected and leaves every register and status unchanged.
- R8: On an accepted switch, status bits [4:0] take the target value and bits [31:5] keep their values. Without an accepted switch, the status word holds.
- R9: A register write in the same cycle as an accepted switch goes to the outgoing mode's view of that register.
- R10: A saved-status write in the same cycle as an accepted switch goes to the outgoing mode's slot. The write takes effect only if the outgoing mode has a slot.
- R11: r0 to r7 and r15 are common to all modes, and so are r8 to r12 outside fast-interrupt mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr_a | input | 4 | Read port A register index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B register index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| ss_wr_en | input | 1 | Saved-status write enable |
| ss_wr_data | input | 32 | Saved-status write data |
| mode_req | input | 1 | Mode-change request, one cycle |
| mode_target | input | 5 | Requested mode encoding |
| mode_o | output | 5 | Current mode |
| status_o | output | 32 | Current status word |
| saved_status_o | output | 32 | Saved status of the current mode, 0 in user/system |

## Verification
The bench targets switches that carry a simultaneous register or saved-status write. If the design applied the write after the swap, the value would show up in the new mode's register and would go missing from the old bank. It also covers leaving fast-interrupt mode for a mode that banks only r13/r14. A design that did not restore r8 to r12 would leak the fast-interrupt values into user code. User↔system moves are tested because reloading from the shared bank in that case would return stale r13/r14 contents. Same-mode and illegal targets are tested because a design without those guards would save and reload a bank, or write garbage into the mode field.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NREG   = 16;
  localparam int unsigned MODE_W = 5;
  localparam int unsigned NBANK  = 6;
  localparam int unsigned BIDX_W = $clog2(NBANK);
  localparam int unsigned HI_LO  = 8;
  localparam int unsigned HI_N   = 5;
  localparam int unsigned SP_IDX = 13;
  localparam int unsigned LR_IDX = 14;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [BIDX_W-1:0] bidx_t;

  localparam mode_t M_USR = 5'h10;
  localparam mode_t M_FIQ = 5'h11;
  localparam mode_t M_IRQ = 5'h12;
  localparam mode_t M_SVC = 5'h13;
  localparam mode_t M_ABT = 5'h17;
  localparam mode_t M_UND = 5'h1B;
  localparam mode_t M_SYS = 5'h1F;

  function automatic logic mode_ok(mode_t m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bidx_t bank_of(mode_t m);
    case (m)
      M_FIQ:   return bidx_t'(1);
      M_IRQ:   return bidx_t'(2);
      M_SVC:   return bidx_t'(3);
      M_ABT:   return bidx_t'(4);
      M_UND:   return bidx_t'(5);
      default: return bidx_t'(0);
    endcase
  endfunction

  function automatic logic has_saved(mode_t m);
    return mode_ok(m) && (m != M_USR) && (m != M_SYS);
  endfunction
endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
  import brf_pkg::*;
(
  input  mode_t mode_i,
  output logic  ok_o,
  output bidx_t bidx_o,
  output logic  fiq_o,
  output logic  saved_o
);
  always_comb begin
    ok_o    = mode_ok(mode_i);
    bidx_o  = bank_of(mode_i);
    fiq_o   = (mode_i == M_FIQ);
    saved_o = has_saved(mode_i);
  end
endmodule

// File: rtl/brf_bank_store.sv
module brf_bank_store #(
  parameter int unsigned W  = 32,
  parameter int unsigned NB = 6,
  localparam int unsigned IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_en,
  input  logic [IW-1:0] save_idx,
  input  logic [W-1:0]  save_sp,
  input  logic [W-1:0]  save_lr,
  input  logic          save_ss_en,
  input  logic [W-1:0]  save_ss,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_sp,
  output logic [W-1:0]  rd_lr,
  output logic [W-1:0]  rd_ss
);
  logic [W-1:0] sp_arr [NB];
  logic [W-1:0] lr_arr [NB];
  logic [W-1:0] ss_arr [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [W-1:0] sp_r, lr_r, ss_r;
    logic hit;
    assign hit = save_en && (save_idx == IW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sp_r <= '0;
        lr_r <= '0;
        ss_r <= '0;
      end else if (hit) begin
        sp_r <= save_sp;
        lr_r <= save_lr;
        if (save_ss_en) ss_r <= save_ss;
      end
    end
    assign sp_arr[b] = sp_r;
    assign lr_arr[b] = lr_r;
    assign ss_arr[b] = ss_r;
  end

  always_comb begin
    rd_sp = '0;
    rd_lr = '0;
    rd_ss = '0;
    if (rd_idx < IW'(NB)) begin
      rd_sp = sp_arr[rd_idx];
      rd_lr = lr_arr[rd_idx];
      rd_ss = ss_arr[rd_idx];
    end
  end
endmodule

// File: rtl/brf_hi_shadow.sv
module brf_hi_shadow #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                save_fiq,
  input  logic                save_com,
  input  logic [N-1:0][W-1:0] din,
  output logic [N-1:0][W-1:0] fiq_q,
  output logic [N-1:0][W-1:0] com_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_q <= '0;
      com_q <= '0;
    end else begin
      if (save_fiq) fiq_q <= din;
      if (save_com) com_q <= din;
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int unsigned W          = XLEN,
  parameter logic [31:0] RST_SP     = 32'h1000_0000,
  parameter logic [31:0] RST_STATUS = 32'h0000_00D3,
  localparam int unsigned AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr_a,
  output logic [W-1:0]  rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [W-1:0]  rd_data_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          ss_wr_en,
  input  logic [W-1:0]  ss_wr_data,
  input  logic          mode_req,
  input  logic [4:0]    mode_target,
  output logic [4:0]    mode_o,
  output logic [W-1:0]  status_o,
  output logic [W-1:0]  saved_status_o
);
  logic [W-1:0] rf_q   [NREG];
  logic [W-1:0] rf_eff [NREG];
  logic [W-1:0] rf_nxt [NREG];
  logic [W-1:0] status_q, ss_q, ss_eff;

  mode_t cur_mode;
  logic  cur_ok, cur_fiq, cur_saved;
  bidx_t cur_bidx;
  logic  tgt_ok, tgt_fiq, tgt_saved;
  bidx_t tgt_bidx;
  logic  do_switch;

  assign cur_mode = status_q[MODE_W-1:0];

  brf_mode_decode u_cur_dec (
    .mode_i (cur_mode), .ok_o (cur_ok), .bidx_o (cur_bidx),
    .fiq_o  (cur_fiq),  .saved_o (cur_saved)
  );

  brf_mode_decode u_tgt_dec (
    .mode_i (mode_target), .ok_o (tgt_ok), .bidx_o (tgt_bidx),
    .fiq_o  (tgt_fiq),     .saved_o (tgt_saved)
  );

  assign do_switch = mode_req && tgt_ok && cur_ok && (mode_target != cur_mode);

  always_comb begin
    for (int i = 0; i < NREG; i++)
      rf_eff[i] = (wr_en && wr_addr == AW'(i)) ? wr_data : rf_q[i];
    ss_eff = (ss_wr_en && cur_saved) ? ss_wr_data : ss_q;
  end

  logic [W-1:0] bk_sp, bk_lr, bk_ss;

  brf_bank_store #(.W(W), .NB(NBANK)) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .save_en    (do_switch),
    .save_idx   (cur_bidx),
    .save_sp    (rf_eff[SP_IDX]),
    .save_lr    (rf_eff[LR_IDX]),
    .save_ss_en (cur_saved),
    .save_ss    (ss_eff),
    .rd_idx     (tgt_bidx),
    .rd_sp      (bk_sp),
    .rd_lr      (bk_lr),
    .rd_ss      (bk_ss)
  );

  logic [HI_N-1:0][W-1:0] hi_din, hi_fiq, hi_com;

  for (genvar k = 0; k < HI_N; k++) begin : g_hi
    assign hi_din[k] = rf_eff[HI_LO+k];
  end

  brf_hi_shadow #(.W(W), .N(HI_N)) u_hi (
    .clk      (clk),
    .rst_n    (rst_n),
    .save_fiq (do_switch && cur_fiq),
    .save_com (do_switch && tgt_fiq),
    .din      (hi_din),
    .fiq_q    (hi_fiq),
    .com_q    (hi_com)
  );

  always_comb begin
    for (int i = 0; i < NREG; i++) rf_nxt[i] = rf_eff[i];
    if (do_switch) begin
      if (tgt_bidx != cur_bidx) begin
        rf_nxt[SP_IDX] = bk_sp;
        rf_nxt[LR_IDX] = bk_lr;
      end
      for (int k = 0; k < HI_N; k++) begin
        if (tgt_fiq)      rf_nxt[HI_LO+k] = hi_fiq[k];
        else if (cur_fiq) rf_nxt[HI_LO+k] = hi_com[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        rf_q[i] <= (i == SP_IDX) ? RST_SP : '0;
      status_q <= W'(RST_STATUS);
      ss_q     <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= rf_nxt[i];
      if (do_switch) begin
        status_q <= {status_q[W-1:MODE_W], mode_target};
        ss_q     <= tgt_saved ? bk_ss : '0;
      end else begin
        ss_q <= ss_eff;
      end
    end
  end

  assign rd_data_a      = rf_q[rd_addr_a];
  assign rd_data_b      = rf_q[rd_addr_b];
  assign mode_o         = cur_mode;
  assign status_o       = status_q;
  assign saved_status_o = ss_q;
endmodule

// File: rtl/brf_checker.sv
module brf_checker
  import brf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        mode_req,
  input logic [4:0]  mode_target,
  input logic        ss_wr_en,
  input logic [4:0]  mode_o,
  input logic [31:0] status_o,
  input logic [31:0] saved_status_o
);
  logic accepted;
  assign accepted = mode_req && mode_ok(mode_target) && (mode_target != mode_o);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_req |=> $stable(status_o));

  p_field_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> (mode_o == $past(mode_target)) && (status_o[31:5] == $past(status_o[31:5])));

  p_same_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && mode_target == mode_o && !ss_wr_en) |=> $stable(status_o) && $stable(saved_status_o));

  p_bad_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && !mode_ok(mode_target)) |=> $stable(status_o));

  p_legal_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok(mode_o));

  p_no_saved_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_USR || mode_o == M_SYS) |-> saved_status_o == 32'h0);
endmodule

bind banked_regfile brf_checker u_brf_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_req       (mode_req),
  .mode_target    (mode_target),
  .ss_wr_en       (ss_wr_en),
  .mode_o         (mode_o),
  .status_o       (status_o),
  .saved_status_o (saved_status_o)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;
  localparam logic [4:0] USR = 5'h10, FIQ = 5'h11, IRQ = 5'h12, SVC = 5'h13,
                         ABT = 5'h17, UND = 5'h1B, SYS = 5'h1F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0, ss_wr_data = '0;
  logic        wr_en = 1'b0, ss_wr_en = 1'b0, mode_req = 1'b0;
  logic [4:0]  mode_target = '0, mode_o;
  logic [31:0] status_o, saved_status_o;

  always #2 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ss_wr_en(ss_wr_en), .ss_wr_data(ss_wr_data),
    .mode_req(mode_req), .mode_target(mode_target),
    .mode_o(mode_o), .status_o(status_o), .saved_status_o(saved_status_o)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // Reference: physical storage per mode, views computed on access
  logic [31:0] m_com [16];
  logic [31:0] m_fq  [16];
  logic [31:0] m_sp  [32];
  logic [31:0] m_lr  [32];
  logic [31:0] m_ss  [32];
  logic [31:0] m_st;

  function automatic bit legal(logic [4:0] m);
    return m == USR || m == FIQ || m == IRQ || m == SVC || m == ABT || m == UND || m == SYS;
  endfunction
  function automatic bit excm(logic [4:0] m);
    return m == IRQ || m == SVC || m == ABT || m == UND;
  endfunction

  function automatic logic [31:0] m_read(int i);
    logic [4:0] m = m_st[4:0];
    if (m == FIQ && i >= 8 && i <= 14) return m_fq[i];
    if (excm(m) && i == 13) return m_sp[m];
    if (excm(m) && i == 14) return m_lr[m];
    return m_com[i];
  endfunction

  task automatic m_write(int i, logic [31:0] v);
    logic [4:0] m = m_st[4:0];
    if (m == FIQ && i >= 8 && i <= 14) m_fq[i] = v;
    else if (excm(m) && i == 13) m_sp[m] = v;
    else if (excm(m) && i == 14) m_lr[m] = v;
    else m_com[i] = v;
  endtask

  function automatic logic [31:0] m_saved();
    logic [4:0] m = m_st[4:0];
    return (m == FIQ || excm(m)) ? m_ss[m] : 32'h0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "mode", {27'h0, mode_o}, {27'h0, m_st[4:0]});
    chk("R8", "status", status_o, m_st);
    chk(tag, "saved", saved_status_o, m_saved());
    for (int i = 0; i < 16; i++) begin
      rd_addr_a = 4'(i);
      rd_addr_b = 4'(15 - i);
      #0.05;
      chk(tag, $sformatf("portA r%0d", i), rd_data_a, m_read(i));
      chk(tag, $sformatf("portB r%0d", 15 - i), rd_data_b, m_read(15 - i));
    end
  endtask

  task automatic step(bit we, int wa, logic [31:0] wd, bit sswe, logic [31:0] ssd,
                      bit req, logic [4:0] tgt, string tag);
    wr_en = we; wr_addr = 4'(wa); wr_data = wd;
    ss_wr_en = sswe; ss_wr_data = ssd;
    mode_req = req; mode_target = tgt;
    @(posedge clk);
    if (we) m_write(wa, wd);
    if (sswe && (m_st[4:0] == FIQ || excm(m_st[4:0]))) m_ss[m_st[4:0]] = ssd;
    if (req && legal(tgt) && tgt != m_st[4:0]) m_st[4:0] = tgt;
    #1;
    wr_en = 0; ss_wr_en = 0; mode_req = 0;
    check_all(tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_com[i] = 0; m_fq[i] = 0; end
    for (int i = 0; i < 32; i++) begin m_sp[i] = 0; m_lr[i] = 0; m_ss[i] = 0; end
    m_sp[SVC] = 32'h1000_0000;
    m_st = 32'h0000_00D3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check_all("R1");

    // R2/R11: fill all registers in supervisor mode
    for (int i = 0; i < 16; i++) step(1, i, 32'hA500_0000 + i, 0, 0, 0, 0, "R2");
    // R4: interrupt mode has its own r13/r14/saved status
    step(0, 0, 0, 0, 0, 1, IRQ, "R4");
    step(1, 13, 32'h1111_0013, 0, 0, 0, 0, "R4");
    step(1, 14, 32'h1111_0014, 1, 32'h6000_0012, 0, 0, "R4");
    // R9: write lands in the outgoing mode's view
    step(1, 13, 32'h1212_1313, 0, 0, 1, FIQ, "R9");
    // R5: fast-interrupt private r8..r14
    for (int i = 8; i < 15; i++) step(1, i, 32'hF0F0_0000 + i, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 32'h8000_0011, 0, 0, "R5");
    step(1, 9, 32'hF9F9_F9F9, 0, 0, 1, USR, "R5");
    // R3: user and system share r13/r14, no saved status
    step(1, 13, 32'h5555_0013, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, SYS, "R3");
    step(1, 14, 32'h5555_0014, 1, 32'hDEAD_BEEF, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, USR, "R3");
    // R6 / R7
    step(0, 0, 0, 0, 0, 1, USR, "R6");
    step(0, 0, 0, 0, 0, 1, 5'h05, "R7");
    step(1, 2, 32'h0202_0202, 0, 0, 1, 5'h00, "R7");
    step(0, 0, 0, 0, 0, 1, 5'h18, "R7");
    // R4: revisit interrupt mode, then abort/undefined/supervisor
    step(0, 0, 0, 0, 0, 1, IRQ, "R4");
    step(0, 0, 0, 0, 0, 1, ABT, "R4");
    step(1, 13, 32'hABAB_0013, 1, 32'h1000_0017, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 1, UND, "R4");
    step(1, 3, 32'h3333_3333, 0, 0, 0, 0, "R11");
    step(1, 14, 32'hCDCD_0014, 0, 0, 1, SVC, "R9");
    step(0, 0, 0, 0, 0, 1, ABT, "R4");
    step(0, 0, 0, 0, 0, 1, UND, "R4");
    step(0, 0, 0, 0, 0, 1, SVC, "R11");
    // R10: saved-status write together with a switch
    step(0, 0, 0, 1, 32'h2000_0013, 1, FIQ, "R10");
    step(1, 10, 32'hFAFA_0010, 1, 32'h3000_0011, 1, IRQ, "R10");
    step(0, 0, 0, 0, 0, 1, SVC, "R10");
    step(0, 0, 0, 0, 0, 1, FIQ, "R5");
    step(1, 15, 32'h0000_8000, 0, 0, 1, SYS, "R11");
    step(0, 0, 0, 1, 32'h1234_5678, 1, IRQ, "R3");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule